// File: doc/BRIEF.md
# Dual-Compare Interval Timer Channel

This block is one timer channel with a 16-bit up-counter that advances only on cycles where a service strobe is high and the channel is allowed to run. The counter climbs to a programmed terminal value, wraps to zero and raises a one-cycle end-of-count pulse. In single-limit mode only the first compare register bounds the count. In alternating mode the channel swaps between two compare registers, so its output pin is a square wave whose high and low times are set independently.

A small write port loads the control word, the two compare registers and the count itself. The channel can run forever or switch itself off when a sequence finishes. An optional external enable, passed through a two-flop synchronizer, can gate counting on top of the software enable. The end-of-count pulse is meant for an interrupt request line.

Top module: `dual_cmp_timer`

## Requirements
- R1: In alternating mode (control bit 3 = 1) `tmr_out` is 1 while the first compare register (address 1) bounds the count and 0 while the second (address 2) does. It starts on the first register after reset.
- R2: In alternating, free-running mode with first limit 10 and second limit 20 and a strobe every cycle, `tmr_out` is high for 10 of every 30 strobes.
- R3: At the end of every sequence in alternating mode (the match on the second register) `tmr_out` returns to 1, whether or not free-running is set.
- R4: While the enable state (`en_o`) is 0, service strobes do not change `cnt_o`.
- R5: A write to address 0 loads control bit 0 into the enable state only when control bit 1 of that same write is 1. Otherwise the enable state keeps its value. Bits 2 to 4 are always loaded.
- R6: With free-running (control bit 2) clear, the enable state drops to 0 on the cycle after the sequence ends. In single-limit mode that is the first-register match; in alternating mode it is the second-register match. With bit 2 set, it stays 1.
- R7: With control bit 4 = 1, counting also needs `ext_en`, seen through two synchronizing flops. After `ext_en` rises, the first two strobes do not count and the third does.
- R8: The counter runs 0, 1, ..., limit-1 and then returns to 0 on the next counted strobe.
- R9: In single-limit mode `tmr_out` goes low on the match and stays low until the next service strobe, then returns high.
- R10: A compare value of 0 means a limit of 65536, so the count reaches 65535 before it wraps.
- R11: `eoc` is high for exactly the one cycle after each matching strobe.
- R12: Cycles with `tick` low never advance the counter.
- R13: A write to address 3 loads `cnt_o` with `wr_data` on the next cycle and takes priority over counting. After reset `cnt_o` = 0, `en_o` = 0, `eoc` = 0 and `tmr_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register address: 0 control, 1 first compare, 2 second compare, 3 count |
| wr_data | input | CNT_W | Write data |
| ext_en | input | 1 | Asynchronous external enable |
| tick | input | 1 | Service strobe; counting happens only when high |
| tmr_out | output | 1 | Timer output pin |
| eoc | output | 1 | One-cycle end-of-count pulse |
| cnt_o | output | CNT_W | Current count |
| en_o | output | 1 | Current enable state |

## Verification
The bench builds the channel with CNT_W = 16 and two synchronizer stages, the same values as the defaults. At this width the full-range case (compare value 0) is reached by preloading the count just below 65535 through the count register, instead of waiting for 65536 strobes. Keeping the synchronizer at two stages lets the bench check exactly which strobe is the first one counted after the external enable rises. Small random compare values in the random phase make wraps and mode swaps frequent.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_BITS = 5;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LIM_A = 2'd1,
        SEL_LIM_B = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    // write image of the control word, bit 4 down to bit 0
    typedef struct packed {
        logic ext_gate;
        logic alt_mode;
        logic free_run;
        logic en_load_ok;
        logic en_value;
    } ctrl_word_t;

    // held mode state
    typedef struct packed {
        logic ext_gate;
        logic alt_mode;
        logic free_run;
        logic enable;
    } mode_state_t;

    function automatic ctrl_word_t decode_ctrl(input logic [CTRL_BITS-1:0] w);
        return ctrl_word_t'(w);
    endfunction

    function automatic logic gate_pass(input mode_state_t m, input logic ext_s);
        return m.enable & (~m.ext_gate | ext_s);
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_cfg.sv
module tmr_cfg
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             stop_req,
    output mode_state_t      mode,
    output logic [W-1:0]     lim_a,
    output logic [W-1:0]     lim_b,
    output logic             cnt_ld
);
    reg_sel_e   sel;
    ctrl_word_t cw;
    logic       ctrl_wr;
    logic       en_load;

    assign sel     = reg_sel_e'(wr_sel);
    assign cw      = decode_ctrl(wr_data[CTRL_BITS-1:0]);
    assign ctrl_wr = wr_en & (sel == SEL_CTRL);
    assign en_load = ctrl_wr & cw.en_load_ok;
    assign cnt_ld  = wr_en & (sel == SEL_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= '0;
            lim_a <= '0;
            lim_b <= '0;
        end else begin
            if (ctrl_wr) begin
                mode.ext_gate <= cw.ext_gate;
                mode.alt_mode <= cw.alt_mode;
                mode.free_run <= cw.free_run;
            end
            if (en_load)       mode.enable <= cw.en_value;
            else if (stop_req) mode.enable <= 1'b0;
            if (wr_en && sel == SEL_LIM_A) lim_a <= wr_data;
            if (wr_en && sel == SEL_LIM_B) lim_b <= wr_data;
        end
    end

    AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !cw.en_load_ok && !stop_req) |=> $stable(mode.enable)); // R5

    AST_SELF_STOP: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !en_load) |=> !mode.enable); // R6
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run_ok,
    input  logic         alt_mode,
    input  logic         free_run,
    input  logic [W-1:0] lim_a,
    input  logic [W-1:0] lim_b,
    input  logic         cnt_ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic         pin_out,
    output logic         eoc_q,
    output logic         stop_req
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         on_b_q;
    logic         low_q;
    logic         use_b;
    logic [W-1:0] lim_sel;
    logic [W-1:0] last_val;
    logic         step;
    logic         hit;
    logic         seq_end;

    // limit of 0 wraps to all-ones, giving the full 2^W range
    assign use_b    = alt_mode & on_b_q;
    assign lim_sel  = use_b ? lim_b : lim_a;
    assign last_val = lim_sel - ONE;
    assign step     = tick & run_ok;
    assign hit      = step & (cnt_q == last_val);
    assign seq_end  = hit & (~alt_mode | on_b_q);
    assign stop_req = seq_end & ~free_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            on_b_q <= 1'b0;
            low_q  <= 1'b0;
            eoc_q  <= 1'b0;
        end else begin
            eoc_q <= hit;
            if (cnt_ld)    cnt_q <= ld_val;
            else if (hit)  cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + ONE;
            if (hit && alt_mode) on_b_q <= ~on_b_q;
            if (hit && !alt_mode) low_q <= 1'b1;
            else if (tick)        low_q <= 1'b0;
        end
    end

    assign pin_out = alt_mode ? ~on_b_q : ~low_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hit && !cnt_ld) |=> (cnt_q == '0)); // R8

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (tick && !run_ok && !cnt_ld) |=> $stable(cnt_q)); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_ld) |=> $stable(cnt_q)); // R12

    AST_END_HIGH: assert property (@(posedge clk) disable iff (rst)
        (hit && alt_mode && on_b_q) |=> (!alt_mode || pin_out)); // R3

    AST_EOC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        eoc_q |-> $past(hit)); // R11
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_en,
    input  logic             tick,
    output logic             tmr_out,
    output logic             eoc,
    output logic [CNT_W-1:0] cnt_o,
    output logic             en_o
);
    mode_state_t      mode;
    logic [CNT_W-1:0] lim_a;
    logic [CNT_W-1:0] lim_b;
    logic             cnt_ld;
    logic             stop_req;
    logic             ext_s;
    logic             run_ok;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_en),
        .q   (ext_s)
    );

    tmr_cfg #(.W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .stop_req (stop_req),
        .mode     (mode),
        .lim_a    (lim_a),
        .lim_b    (lim_b),
        .cnt_ld   (cnt_ld)
    );

    assign run_ok = gate_pass(mode, ext_s);

    tmr_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run_ok   (run_ok),
        .alt_mode (mode.alt_mode),
        .free_run (mode.free_run),
        .lim_a    (lim_a),
        .lim_b    (lim_b),
        .cnt_ld   (cnt_ld),
        .ld_val   (wr_data),
        .cnt_q    (cnt_o),
        .pin_out  (tmr_out),
        .eoc_q    (eoc),
        .stop_req (stop_req)
    );

    assign en_o = mode.enable;

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (tick && mode.ext_gate && !ext_s && !cnt_ld) |=> $stable(cnt_o)); // R7
endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    localparam int CNT_W = 16;
    localparam int FULL  = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             ext_en = 1'b0;
    logic             tick = 1'b0;
    logic             tmr_out;
    logic             eoc;
    logic [CNT_W-1:0] cnt_o;
    logic             en_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dual_cmp_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ext_en(ext_en), .tick(tick), .tmr_out(tmr_out), .eoc(eoc),
        .cnt_o(cnt_o), .en_o(en_o)
    );

    // behavioural reference
    int m_cnt, m_a, m_b;
    bit m_en, m_cont, m_dual, m_gate, m_onb, m_low, m_eoc, m_s1, m_s2;

    always @(posedge clk) begin
        int  lim_v, n_cnt;
        bit  act, hit, fin, n_en, n_onb, n_low;
        if (rst) begin
            m_cnt = 0; m_a = 0; m_b = 0; m_en = 0; m_cont = 0; m_dual = 0;
            m_gate = 0; m_onb = 0; m_low = 0; m_eoc = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            act   = tick && m_en && (!m_gate || m_s2);
            lim_v = (m_dual && m_onb) ? m_b : m_a;
            if (lim_v == 0) lim_v = FULL;
            hit   = act && (m_cnt == lim_v - 1);
            fin   = hit && (!m_dual || m_onb);
            n_cnt = m_cnt;
            if (wr_en && wr_sel == 2'd3) n_cnt = wr_data;
            else if (hit) n_cnt = 0;
            else if (act) n_cnt = m_cnt + 1;
            n_onb = (hit && m_dual) ? !m_onb : m_onb;
            n_low = m_low;
            if (hit && !m_dual) n_low = 1;
            else if (tick) n_low = 0;
            n_en = m_en;
            if (wr_en && wr_sel == 2'd0 && wr_data[1]) n_en = wr_data[0];
            else if (fin && !m_cont) n_en = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_cont = wr_data[2]; m_dual = wr_data[3]; m_gate = wr_data[4];
            end
            if (wr_en && wr_sel == 2'd1) m_a = wr_data;
            if (wr_en && wr_sel == 2'd2) m_b = wr_data;
            m_s2 = m_s1; m_s1 = ext_en;
            m_cnt = n_cnt; m_onb = n_onb; m_low = n_low; m_en = n_en; m_eoc = hit;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit m_pin;
            m_pin = m_dual ? !m_onb : !m_low;
            chk(int'(cnt_o) == m_cnt, "R8 count", int'(cnt_o), m_cnt);
            chk(en_o == m_en, "R6 enable", int'(en_o), int'(m_en));
            chk(tmr_out == m_pin, "R1 pin", int'(tmr_out), int'(m_pin));
            chk(eoc == m_eoc, "R11 eoc", int'(eoc), int'(m_eoc));
        end
    end

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[CNT_W-1:0];
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int highs;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        chk(tmr_out == 1 && cnt_o == 0 && en_o == 0 && eoc == 0, "R13 reset",
            int'({tmr_out, en_o, eoc}), 4);

        // single mode, one-shot, limit 5
        wr(1, 5);
        wr(0, 'b00011);
        ticks(4);
        chk(cnt_o == 4, "R8 count up", int'(cnt_o), 4);
        ticks(1);
        chk(cnt_o == 0, "R8 wrap", int'(cnt_o), 0);
        chk(eoc == 1, "R11 pulse", int'(eoc), 1);
        chk(tmr_out == 0, "R9 low on match", int'(tmr_out), 0);
        chk(en_o == 0, "R6 single stop", int'(en_o), 0);
        cyc();
        chk(eoc == 0, "R11 one cycle", int'(eoc), 0);
        chk(tmr_out == 0, "R9 low until tick", int'(tmr_out), 0);
        ticks(3);
        chk(tmr_out == 1, "R9 high after tick", int'(tmr_out), 1);
        chk(cnt_o == 0, "R4 disabled hold", int'(cnt_o), 0);

        // enable write without permission bit
        wr(0, 'b00001);
        chk(en_o == 0, "R5 enable gated", int'(en_o), 0);

        // free-running single, no strobes
        wr(0, 'b00111);
        repeat (5) cyc();
        chk(cnt_o == 0, "R12 no tick", int'(cnt_o), 0);
        ticks(7);
        chk(cnt_o == 2, "R8 free run", int'(cnt_o), 2);
        chk(en_o == 1, "R6 free run keeps enable", int'(en_o), 1);

        // alternating, free-running, 10/20
        wr(3, 0);
        wr(1, 10);
        wr(2, 20);
        wr(0, 'b01111);
        highs = 0;
        tick = 1'b1;
        for (int k = 1; k <= 90; k++) begin
            cyc();
            if (tmr_out) highs++;
            if (k == 9)  chk(tmr_out == 1, "R1 first limit high", int'(tmr_out), 1);
            if (k == 10) chk(tmr_out == 0, "R1 second limit low", int'(tmr_out), 0);
        end
        tick = 1'b0;
        chk(highs == 30, "R2 duty", highs, 30);

        // alternating one-shot 3/2
        wr(3, 0);
        wr(1, 3);
        wr(2, 2);
        wr(0, 'b01011);
        ticks(3);
        chk(tmr_out == 0, "R1 on second limit", int'(tmr_out), 0);
        ticks(2);
        chk(tmr_out == 1, "R3 high at end", int'(tmr_out), 1);
        chk(en_o == 0, "R6 alt stop", int'(en_o), 0);

        // external gate
        ext_en = 1'b0;
        wr(3, 0);
        wr(1, 100);
        wr(0, 'b10111);
        ticks(4);
        chk(cnt_o == 0, "R7 gate closed", int'(cnt_o), 0);
        ext_en = 1'b1;
        ticks(2);
        chk(cnt_o == 0, "R7 sync delay", int'(cnt_o), 0);
        ticks(1);
        chk(cnt_o == 1, "R7 third strobe counts", int'(cnt_o), 1);

        // full range
        wr(0, 'b00111);
        wr(1, 0);
        wr(3, 65533);
        chk(cnt_o == 65533, "R13 count load", int'(cnt_o), 65533);
        ticks(2);
        chk(cnt_o == 65535 && eoc == 0, "R10 reach top", int'(cnt_o), 65535);
        ticks(1);
        chk(cnt_o == 0 && eoc == 1, "R10 full wrap", int'(cnt_o), 0);

        // random phase, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 16);
            tick   = ($urandom % 4) != 0;
            ext_en = ($urandom % 8) != 0;
            if (r == 0) begin
                wr_en = 1'b1; wr_sel = 2'd0; wr_data = CNT_W'($urandom & 'h1f);
            end else if (r == 1) begin
                wr_en = 1'b1; wr_sel = 2'(1 + $urandom % 3); wr_data = CNT_W'($urandom & 'hf);
            end else begin
                wr_en = 1'b0;
            end
            cyc();
        end
        wr_en = 1'b0; tick = 1'b0;
        cyc();
        finish_run();
    end
endmodule